// File: doc/BRIEF.md
# Remote Terminal Subsystem Word Transfer Controller

This block is the subsystem-facing data mover of a serial command/response bus remote terminal, running at 6 MHz. The protocol engine feeds it commands and data words that are already decoded and validated. The block moves each 16-bit data word across an 8-bit highway as two bytes, high byte first. A request/acknowledge handshake paces every word, and the receive and transmit directions each have their own acknowledge deadline.

When a command is accepted, the block pulses a command-start line and shows the transfer direction. On receive, it raises a request for each validated word and strobes the two bytes out to the subsystem. When the message ends, it pulses a good-block line, but only if the whole block is correct. The subsystem must treat that pulse as its permission to use the buffered data. On transmit, it requests each word from the subsystem, latches the two bytes, and hands the assembled word to the encoder. A sticky failure flag records any acknowledge deadline that was missed. That flag feeds the subsystem-handshake bit of the built-in-test word.

Top module: `rt_xfer_ctl`

## Requirements
- R1: One cycle after `cmd_valid` is sampled, `cmd_start_n` is low for exactly one cycle. From that cycle on, `dir_tx` is 0 for a receive command and 1 for a transmit command.
- R2: On receive, `req_n` falls after each validated data word. An `ack_n` low sampled within the first 9 cycles of `req_n` low is accepted. If it is not seen, `req_n` is low for exactly 9 cycles, then rises, `ss_fail` sets, and no good-block pulse follows.
- R3: On transmit, `req_n` is low in the cycle right after the command-start pulse. Each later word is requested only after a `tx_word_start` pulse. Every request gets its own 81-cycle acknowledge window, and a window that expires sets `ss_fail`.
- R4: Each word crosses as two one-cycle `strobe` pulses: first with `hi_sel`=1 carrying bits 15:8, then with `hi_sel`=0 carrying bits 7:0. `req_n` rises after the low byte. On receive the bytes appear on `hwy_out`. On transmit the bytes are taken from `hwy_in`, and the assembled word is on `tx_word` while `tx_word_load` is high for one cycle, in the cycle where `req_n` rises.
- R5: `cur_wc` reads 0 in the command-start cycle. It increases by one at the falling edge of each low-byte strobe.
- R6: A word-count field of 0 stands for 32 words.
- R7: After `msg_end`, `good_blk_n` pulses low for one cycle only if no `rx_word_err` was seen and the number of words transferred equals the commanded count. Otherwise it stays high.
- R8: For the receiving side of a terminal-to-terminal transfer, with a word already waiting, `req_n` first falls exactly 422 cycles after the command-start cycle. That is the 420-cycle hold-off plus two cycles.
- R9: A `cmd_valid` during a block abandons that block with no good-block pulse, and a new block starts with its count cleared.
- R10: After reset, the lines `cmd_start_n`, `req_n` and `good_blk_n` are high, `strobe` is 0, `hi_sel` is 1, and `cur_wc` and `ss_fail` are 0. `ss_fail` stays set until reset.
- R11: After the last commanded transmit word, no further request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 6 MHz clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle pulse: validated command for this terminal |
| cmd_tx | input | 1 | Command direction, 1 = transmit |
| cmd_r2r | input | 1 | Receive leg of a terminal-to-terminal transfer |
| cmd_wc | input | 5 | Word-count field, 0 means 32 |
| rx_word_valid | input | 1 | One-cycle pulse: validated received data word |
| rx_word | input | 16 | Received data word |
| rx_word_err | input | 1 | One-cycle pulse: invalid word seen in the block |
| msg_end | input | 1 | One-cycle pulse: received message finished |
| tx_word_start | input | 1 | One-cycle pulse: encoder began sending the current word |
| ack_n | input | 1 | Subsystem acknowledge, active low |
| hwy_in | input | 8 | Byte from subsystem on transmit |
| cmd_start_n | output | 1 | Command-start pulse, active low |
| dir_tx | output | 1 | Direction, 1 = transmit |
| req_n | output | 1 | Word request, active low |
| strobe | output | 1 | Byte strobe, one cycle per byte |
| hi_sel | output | 1 | 1 = high byte on highway |
| hwy_out | output | 8 | Byte to subsystem on receive |
| tx_word | output | 16 | Assembled transmit word |
| tx_word_load | output | 1 | One-cycle pulse: `tx_word` valid |
| good_blk_n | output | 1 | Whole-block valid pulse, active low |
| cur_wc | output | 6 | Current word count |
| ss_fail | output | 1 | Sticky subsystem handshake failure |

## Verification
The properties assume the protocol engine behaves: `cmd_valid`, `rx_word_valid`, `msg_end` and `tx_word_start` are single-cycle pulses, and a new received word does not come before the previous word has finished its handshake. The stimulus keeps to these assumptions. It sends words only after `req_n` has returned high, sends `msg_end` only once the last word is done, and sends `tx_word_start` only while the block waits between transmit words. The one exception is the abandon case, where a command deliberately arrives in the middle of a block.

// File: rtl/rtx_pkg.sv
package rtx_pkg;

    localparam int WC_W  = 5;
    localparam int CNT_W = WC_W + 1;

    typedef enum logic [3:0] {
        ST_IDLE, ST_START, ST_DELAY, ST_RWAIT, ST_RREQ,
        ST_RXFER, ST_GOOD, ST_TREQ, ST_TXFER, ST_TWAIT
    } xfer_st_e;

    typedef enum logic [1:0] {PH_NONE, PH_HI, PH_GAP, PH_LO} byte_ph_e;

    typedef struct packed {
        logic            tx;
        logic            r2r;
        logic [WC_W-1:0] wc;
    } cmd_t;

    // Word-count field to number of words; an all-zero field is the maximum.
    function automatic logic [CNT_W-1:0] wc_words(input logic [WC_W-1:0] f);
        return (f == '0) ? CNT_W'(1 << WC_W) : CNT_W'(f);
    endfunction

endpackage

// File: rtl/rtx_tick.sv
module rtx_tick #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         arm,
    input  logic [W-1:0] arm_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (arm)           cnt_q <= arm_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/rtx_wordcnt.sv
module rtx_wordcnt #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clr) count <= '0;
        else if (inc)   count <= count + 1'b1;
    end
endmodule

// File: rtl/rtx_byte_seq.sv
module rtx_byte_seq
    import rtx_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                kill,
    input  logic                start,
    input  logic [BYTE_W-1:0]   lane_in,
    output logic                strobe,
    output logic                hi_sel,
    output logic                last,
    output logic [2*BYTE_W-1:0] word_q
);
    localparam int LANES = 2;

    byte_ph_e ph_q;

    always_ff @(posedge clk) begin
        if (rst || kill) ph_q <= PH_NONE;
        else begin
            case (ph_q)
                PH_NONE: if (start) ph_q <= PH_HI;
                PH_HI:   ph_q <= PH_GAP;
                PH_GAP:  ph_q <= PH_LO;
                default: ph_q <= PH_NONE;
            endcase
        end
    end

    assign strobe = (ph_q == PH_HI) || (ph_q == PH_LO);
    assign hi_sel = (ph_q != PH_LO);
    assign last   = (ph_q == PH_LO);

    // One capture register per byte lane; lane 1 holds the upper byte.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane_q;
        logic              take;
        assign take = (g == LANES - 1) ? (ph_q == PH_HI) : (ph_q == PH_LO);
        always_ff @(posedge clk) begin
            if (rst)       lane_q <= '0;
            else if (take) lane_q <= lane_in;
        end
        assign word_q[g*BYTE_W +: BYTE_W] = lane_q;
    end
endmodule

// File: rtl/rt_xfer_ctl.sv
module rt_xfer_ctl
    import rtx_pkg::*;
#(
    parameter int BYTE_W       = 8,
    parameter int RX_ACK_CLKS  = 9,
    parameter int TX_ACK_CLKS  = 81,
    parameter int R2R_DLY_CLKS = 420
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic                cmd_tx,
    input  logic                cmd_r2r,
    input  logic [WC_W-1:0]     cmd_wc,
    input  logic                rx_word_valid,
    input  logic [2*BYTE_W-1:0] rx_word,
    input  logic                rx_word_err,
    input  logic                msg_end,
    input  logic                tx_word_start,
    input  logic                ack_n,
    input  logic [BYTE_W-1:0]   hwy_in,
    output logic                cmd_start_n,
    output logic                dir_tx,
    output logic                req_n,
    output logic                strobe,
    output logic                hi_sel,
    output logic [BYTE_W-1:0]   hwy_out,
    output logic [2*BYTE_W-1:0] tx_word,
    output logic                tx_word_load,
    output logic                good_blk_n,
    output logic [CNT_W-1:0]    cur_wc,
    output logic                ss_fail
);
    localparam int WORD_W  = 2 * BYTE_W;
    localparam int TMR_MAX = (R2R_DLY_CLKS > TX_ACK_CLKS) ?
                             ((R2R_DLY_CLKS > RX_ACK_CLKS) ? R2R_DLY_CLKS : RX_ACK_CLKS) :
                             ((TX_ACK_CLKS > RX_ACK_CLKS) ? TX_ACK_CLKS : RX_ACK_CLKS);
    localparam int TMR_W   = $clog2(TMR_MAX + 1);

    xfer_st_e          st_q, st_n;
    cmd_t              cmd_q;
    logic              pend_q, end_pend_q, blk_err_q, load_q, fail_q;
    logic [WORD_W-1:0] rbuf_q, xbuf_q;

    logic              tmr_arm, tmr_zero;
    logic [TMR_W-1:0]  tmr_val;
    logic              seq_go, seq_last, cnt_inc, timeout, rx_act;
    logic [CNT_W-1:0]  words, cnt;

    assign words  = wc_words(cmd_q.wc);
    assign rx_act = !cmd_q.tx && (st_q inside {ST_START, ST_DELAY, ST_RWAIT, ST_RREQ, ST_RXFER});

    // Next-state decode
    always_comb begin
        st_n    = st_q;
        seq_go  = 1'b0;
        timeout = 1'b0;
        case (st_q)
            ST_IDLE:  st_n = ST_IDLE;
            ST_START: st_n = cmd_q.tx ? ST_TREQ : (cmd_q.r2r ? ST_DELAY : ST_RWAIT);
            ST_DELAY: if (tmr_zero) st_n = ST_RWAIT;
            ST_RWAIT: begin
                if (pend_q)          st_n = ST_RREQ;
                else if (end_pend_q) st_n = (!blk_err_q && cnt == words) ? ST_GOOD : ST_IDLE;
            end
            ST_RREQ: begin
                if (!ack_n)        begin st_n = ST_RXFER; seq_go = 1'b1; end
                else if (tmr_zero) begin st_n = ST_IDLE;  timeout = 1'b1; end
            end
            ST_RXFER: if (seq_last) st_n = ST_RWAIT;
            ST_GOOD:  st_n = ST_IDLE;
            ST_TREQ: begin
                if (!ack_n)        begin st_n = ST_TXFER; seq_go = 1'b1; end
                else if (tmr_zero) begin st_n = ST_IDLE;  timeout = 1'b1; end
            end
            ST_TXFER: if (seq_last) st_n = ((cnt + 1'b1) == words) ? ST_IDLE : ST_TWAIT;
            ST_TWAIT: if (tx_word_start) st_n = ST_TREQ;
            default:  st_n = ST_IDLE;
        endcase
        if (cmd_valid) st_n = ST_START;
    end

    // Deadline / hold-off timer is reloaded on entry to each timed state.
    always_comb begin
        tmr_arm = (st_n != st_q) && (st_n inside {ST_DELAY, ST_RREQ, ST_TREQ});
        case (st_n)
            ST_DELAY: tmr_val = TMR_W'(R2R_DLY_CLKS - 1);
            ST_RREQ:  tmr_val = TMR_W'(RX_ACK_CLKS - 1);
            ST_TREQ:  tmr_val = TMR_W'(TX_ACK_CLKS - 1);
            default:  tmr_val = '0;
        endcase
    end

    assign cnt_inc = seq_last && (st_q inside {ST_RXFER, ST_TXFER}) && !cmd_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            cmd_q      <= '0;
            pend_q     <= 1'b0;
            end_pend_q <= 1'b0;
            blk_err_q  <= 1'b0;
            load_q     <= 1'b0;
            fail_q     <= 1'b0;
            rbuf_q     <= '0;
            xbuf_q     <= '0;
        end else begin
            st_q   <= st_n;
            fail_q <= fail_q | timeout;
            load_q <= (st_q == ST_TXFER) && seq_last && !cmd_valid;
            if (cmd_valid) begin
                cmd_q      <= '{tx: cmd_tx, r2r: cmd_r2r, wc: cmd_wc};
                pend_q     <= 1'b0;
                end_pend_q <= 1'b0;
                blk_err_q  <= 1'b0;
            end else begin
                if (rx_act && rx_word_valid) begin
                    pend_q <= 1'b1;
                    rbuf_q <= rx_word;
                end else if (st_q == ST_RWAIT) begin
                    pend_q <= 1'b0;
                end
                if (st_q == ST_RWAIT && pend_q) xbuf_q <= rbuf_q;
                if (rx_act && rx_word_err)      blk_err_q <= 1'b1;
                if (rx_act && msg_end)          end_pend_q <= 1'b1;
            end
        end
    end

    rtx_tick #(.W(TMR_W)) u_tick (
        .clk(clk), .rst(rst), .arm(tmr_arm), .arm_val(tmr_val), .zero(tmr_zero)
    );

    rtx_wordcnt #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .clr(cmd_valid), .inc(cnt_inc), .count(cnt)
    );

    rtx_byte_seq #(.BYTE_W(BYTE_W)) u_seq (
        .clk(clk), .rst(rst), .kill(cmd_valid), .start(seq_go && !cmd_valid),
        .lane_in(hwy_in), .strobe(strobe), .hi_sel(hi_sel), .last(seq_last),
        .word_q(tx_word)
    );

    assign cmd_start_n  = (st_q != ST_START);
    assign good_blk_n   = (st_q != ST_GOOD);
    assign req_n        = !(st_q inside {ST_RREQ, ST_RXFER, ST_TREQ, ST_TXFER});
    assign dir_tx       = cmd_q.tx;
    assign hwy_out      = hi_sel ? xbuf_q[WORD_W-1 -: BYTE_W] : xbuf_q[BYTE_W-1:0];
    assign tx_word_load = load_q;
    assign cur_wc       = cnt;
    assign ss_fail      = fail_q;
endmodule

// File: rtl/rtx_chk.sv
module rtx_chk #(
    parameter int CW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          cmd_valid,
    input logic          cmd_start_n,
    input logic          dir_tx,
    input logic          req_n,
    input logic          strobe,
    input logic          hi_sel,
    input logic          good_blk_n,
    input logic [CW-1:0] cur_wc,
    input logic          ss_fail
);
    // R1
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_start_n |=> cmd_start_n);

    // R4
    byte_order_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe && !hi_sel) |-> $past(hi_sel));

    // R4
    strobe_req_chk: assert property (@(posedge clk) disable iff (rst)
        strobe |-> !req_n);

    // R5
    wc_step_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(strobe) && !$past(hi_sel) && !$past(cmd_valid))
            |-> (cur_wc == CW'($past(cur_wc) + 1'b1)));

    // R5
    wc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> (cur_wc == '0));

    // R7
    good_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !good_blk_n |-> (req_n && !dir_tx));

    // R7
    good_once_chk: assert property (@(posedge clk) disable iff (rst)
        !good_blk_n |=> good_blk_n);

    // R10
    fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ss_fail |=> ss_fail);
endmodule

bind rt_xfer_ctl rtx_chk #(.CW(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_start_n(cmd_start_n),
    .dir_tx(dir_tx), .req_n(req_n), .strobe(strobe), .hi_sel(hi_sel),
    .good_blk_n(good_blk_n), .cur_wc(cur_wc), .ss_fail(ss_fail)
);

// File: tb/sim_rt_xfer_ctl.sv
module sim_rt_xfer_ctl;
    import rtx_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0, cmd_tx = 1'b0, cmd_r2r = 1'b0;
    logic [4:0]  cmd_wc = '0;
    logic        rx_word_valid = 1'b0, rx_word_err = 1'b0, msg_end = 1'b0;
    logic [15:0] rx_word = '0;
    logic        tx_word_start = 1'b0, ack_n = 1'b1;
    logic [15:0] tx_src = '0;
    logic [7:0]  hwy_in;
    logic        cmd_start_n, dir_tx, req_n, strobe, hi_sel, tx_word_load, good_blk_n, ss_fail;
    logic [7:0]  hwy_out;
    logic [15:0] tx_word;
    logic [5:0]  cur_wc;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    assign hwy_in = hi_sel ? tx_src[15:8] : tx_src[7:0];

    rt_xfer_ctl u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_tx(cmd_tx), .cmd_r2r(cmd_r2r),
        .cmd_wc(cmd_wc), .rx_word_valid(rx_word_valid), .rx_word(rx_word),
        .rx_word_err(rx_word_err), .msg_end(msg_end), .tx_word_start(tx_word_start),
        .ack_n(ack_n), .hwy_in(hwy_in), .cmd_start_n(cmd_start_n), .dir_tx(dir_tx),
        .req_n(req_n), .strobe(strobe), .hi_sel(hi_sel), .hwy_out(hwy_out),
        .tx_word(tx_word), .tx_word_load(tx_word_load), .good_blk_n(good_blk_n),
        .cur_wc(cur_wc), .ss_fail(ss_fail)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic logic [15:0] pat(input int s, input int i);
        return 16'(s * 16'h1357 + i * 16'h0A1B + 16'h5AC3);
    endfunction

    function automatic int nwords(input int wc);
        return (wc == 0) ? 32 : wc;
    endfunction

    task automatic send_cmd(input bit tx, input bit r2r, input int wc);
        cmd_valid = 1'b1; cmd_tx = tx; cmd_r2r = r2r; cmd_wc = 5'(wc);
        tick();
        cmd_valid = 1'b0;
    endtask

    task automatic pulse_end();
        msg_end = 1'b1; tick(); msg_end = 1'b0;
    endtask

    task automatic count_good(input int exp, input string tag);
        int seen = 0;
        for (int k = 0; k < 6; k++) begin
            tick();
            if (!good_blk_n) seen++;
        end
        chk(seen == exp, tag, seen, exp);
    endtask

    task automatic rx_one(input logic [15:0] w, input int d, input int exp_cnt);
        int n = 0;
        int nst = 0;
        rx_word = w; rx_word_valid = 1'b1; tick(); rx_word_valid = 1'b0;
        while (req_n && n < 30) begin tick(); n++; end
        chk(req_n == 0, "R2 request after word", req_n, 0);
        repeat (d) tick();
        ack_n = 1'b0;
        n = 0;
        do begin
            tick(); n++;
            if (strobe) begin
                if (nst == 0) begin
                    chk(hi_sel == 1, "R4 first byte is high", hi_sel, 1);
                    chk(hwy_out == w[15:8], "R4 high byte value", hwy_out, w[15:8]);
                end else begin
                    chk(hi_sel == 0, "R4 second byte is low", hi_sel, 0);
                    chk(hwy_out == w[7:0], "R4 low byte value", hwy_out, w[7:0]);
                end
                nst++;
            end
        end while (!req_n && n < 40);
        chk(nst == 2, "R4 two strobes per word", nst, 2);
        chk(cur_wc == exp_cnt, "R5 count after word", cur_wc, exp_cnt);
        ack_n = 1'b1;
    endtask

    task automatic rx_msg(input int wc, input int nw, input int err_at, input bit exp_good,
                          input string tag);
        send_cmd(1'b0, 1'b0, wc);
        chk(cmd_start_n == 0, "R1 start pulse low", cmd_start_n, 0);
        chk(dir_tx == 0, "R1 receive direction", dir_tx, 0);
        chk(cur_wc == 0, "R5 count cleared", cur_wc, 0);
        tick();
        chk(cmd_start_n == 1, "R1 start pulse one cycle", cmd_start_n, 1);
        for (int i = 0; i < nw; i++) begin
            if (i == err_at) begin rx_word_err = 1'b1; tick(); rx_word_err = 1'b0; end
            rx_one(pat(wc, i), (i + wc) % 9, i + 1);
        end
        pulse_end();
        count_good(exp_good ? 1 : 0, tag);
    endtask

    task automatic tx_msg(input int wc, input string tag);
        int nw = nwords(wc);
        send_cmd(1'b1, 1'b0, wc);
        chk(cmd_start_n == 0, "R1 start pulse low", cmd_start_n, 0);
        chk(dir_tx == 1, "R1 transmit direction", dir_tx, 1);
        chk(cur_wc == 0, "R5 count cleared", cur_wc, 0);
        tick();
        chk(req_n == 0, "R3 first request with status word", req_n, 0);
        for (int i = 0; i < nw; i++) begin
            int n = 0;
            int d = (i == 1) ? 80 : (i * 3) % 7;
            tx_src = pat(wc + 40, i);
            if (i > 0) begin
                repeat (3) tick();
                chk(req_n == 1, "R3 waits for word start", req_n, 1);
                tx_word_start = 1'b1; tick(); tx_word_start = 1'b0;
                chk(req_n == 0, "R3 request on word start", req_n, 0);
            end
            repeat (d) tick();
            ack_n = 1'b0;
            do begin tick(); n++; end while (!req_n && n < 40);
            chk(tx_word_load == 1, "R4 load pulse", tx_word_load, 1);
            chk(tx_word == tx_src, "R4 assembled word", tx_word, tx_src);
            chk(cur_wc == i + 1, "R5 count after word", cur_wc, i + 1);
            ack_n = 1'b1;
        end
        tick();
        tx_word_start = 1'b1; tick(); tx_word_start = 1'b0;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk(req_n == 1, tag, req_n, 1);
        end
        chk(cur_wc == nw, "R11 final count", cur_wc, nw);
    endtask

    task automatic finish_up();
        done_flag = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            chk(1'b0, "watchdog", 0, 1);
            finish_up();
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R10 reset state
        chk(cmd_start_n == 1, "R10 start line idle", cmd_start_n, 1);
        chk(req_n == 1, "R10 request idle", req_n, 1);
        chk(good_blk_n == 1, "R10 good line idle", good_blk_n, 1);
        chk(strobe == 0 && hi_sel == 1, "R10 byte lines idle", strobe, 0);
        chk(cur_wc == 0, "R10 count zero", cur_wc, 0);
        chk(ss_fail == 0, "R10 failure clear", ss_fail, 0);

        // Receive sweep, all valid
        rx_msg(1, 1, -1, 1'b1, "R7 good block wc1");
        rx_msg(2, 2, -1, 1'b1, "R7 good block wc2");
        rx_msg(3, 3, -1, 1'b1, "R7 good block wc3");
        rx_msg(7, 7, -1, 1'b1, "R7 good block wc7");
        rx_msg(12, 12, -1, 1'b1, "R7 good block wc12");
        rx_msg(0, 32, -1, 1'b1, "R6 field zero is 32 words");
        chk(ss_fail == 0, "R2 late acknowledge inside window", ss_fail, 0);

        // Receive blocks that must not validate
        rx_msg(3, 2, -1, 1'b0, "R7 short block");
        rx_msg(2, 3, -1, 1'b0, "R7 extra word");
        rx_msg(0, 31, -1, 1'b0, "R6 31 of 32 words");
        rx_msg(4, 4, 2, 1'b0, "R7 word error");

        // Transmit sweep
        tx_msg(1, "R11 no request after wc1");
        tx_msg(3, "R11 no request after wc3");
        tx_msg(5, "R11 no request after wc5");
        tx_msg(0, "R11 no request after 32 words");
        chk(ss_fail == 0, "R3 acknowledge at cycle 81 accepted", ss_fail, 0);

        // R8 terminal-to-terminal hold-off
        begin
            int k = 0;
            send_cmd(1'b0, 1'b1, 1);
            chk(cmd_start_n == 0, "R8 start pulse", cmd_start_n, 0);
            rx_word = pat(99, 0); rx_word_valid = 1'b1; tick(); rx_word_valid = 1'b0;
            k = 1;
            while (req_n && k < 600) begin tick(); k++; end
            chk(k == 422, "R8 first request delay", k, 422);
            ack_n = 1'b0;
            k = 0;
            do begin tick(); k++; end while (!req_n && k < 40);
            ack_n = 1'b1;
            chk(cur_wc == 1, "R8 word moved", cur_wc, 1);
            pulse_end();
            count_good(1, "R8 good block after hold-off");
        end

        // R9 abandon on a new command
        send_cmd(1'b0, 1'b0, 2);
        tick();
        rx_one(pat(7, 0), 1, 1);
        rx_one(pat(7, 1), 2, 2);
        send_cmd(1'b0, 1'b0, 2);
        chk(cmd_start_n == 0, "R9 new start pulse", cmd_start_n, 0);
        chk(cur_wc == 0, "R9 count restarted", cur_wc, 0);
        tick();
        pulse_end();
        count_good(0, "R9 abandoned block has no good pulse");
        rx_msg(2, 2, -1, 1'b1, "R9 recovery block");

        // R2 receive deadline expiry
        begin
            int k = 0;
            send_cmd(1'b0, 1'b0, 1);
            tick();
            rx_word = pat(5, 5); rx_word_valid = 1'b1; tick(); rx_word_valid = 1'b0;
            while (req_n && k < 30) begin tick(); k++; end
            k = 0;
            while (!req_n && k < 200) begin k++; tick(); end
            chk(k == 9, "R2 request window length", k, 9);
            chk(ss_fail == 1, "R2 failure flagged", ss_fail, 1);
            pulse_end();
            count_good(0, "R2 no good block after failure");
        end
        rx_msg(1, 1, -1, 1'b1, "R7 good block after failure");
        chk(ss_fail == 1, "R10 failure is sticky", ss_fail, 1);

        // Reset clears the flag
        rst = 1'b1; tick(); tick(); rst = 1'b0; tick();
        chk(ss_fail == 0, "R10 reset clears failure", ss_fail, 0);

        // R3 transmit deadline re-armed per word, then expiry
        begin
            int k = 0;
            send_cmd(1'b1, 1'b0, 2);
            tick();
            tx_src = pat(3, 0);
            repeat (80) tick();
            ack_n = 1'b0;
            do begin tick(); k++; end while (!req_n && k < 40);
            ack_n = 1'b1;
            chk(ss_fail == 0, "R3 first word inside window", ss_fail, 0);
            tx_word_start = 1'b1; tick(); tx_word_start = 1'b0;
            k = 0;
            while (!req_n && k < 300) begin k++; tick(); end
            chk(k == 81, "R3 re-armed window length", k, 81);
            chk(ss_fail == 1, "R3 failure flagged", ss_fail, 1);
        end

        finish_up();
    end
endmodule